// File: doc/BRIEF.md
# Flexible Serially Concatenated LDPC Encoder

This block turns one frame of K information bits into a systematic codeword. The systematic bits pass straight through to the output as they arrive. The same bits are also written into an internal bit store. Once the frame is complete, the block reads the store back in a permuted order and emits the parity bits. The parity path is a chain of five steps:

- a two-state outer code with a tail-biting start, where each outer bit is computed as `c_i = b_i XOR b_{(i-1) mod K}`;
- a repetition that uses every outer bit twice, giving 2K bit positions;
- an interleaver that visits those 2K positions in the order (step·n + offset) mod 2K;
- a parity check that XORs each run of J consecutive interleaved bits into one value;
- an accumulator that sums those parity-check values, starts from zero each frame and is never terminated.

The frame length K and the group width J are set at run time with each frame. Setting J = 2^jlog with jlog from 1 to 4 gives code rates 1/2, 2/3, 4/5 and 8/9, since the rate is J/(J+2). The frame length changes only the interleaver span. The interleaver step and offset are also supplied with each frame. The block checks the whole configuration when the first bit of a frame arrives. If the configuration is not valid, the block flags an error and discards that frame.

Top module: `flex_sc_ldpc_enc`

## Requirements
- R1: Inside a valid frame, each accepted input bit appears on the output in the same cycle, with out_is_parity=0 and out_last=0. The bits appear in arrival order, and in_ready equals out_ready while they pass through. The frame ends on its K-th accepted bit.
- R2: The outer bit for index i is b_i XOR b_{(i-1) mod K}, so outer bit 0 uses b_{K-1}. Interleaver positions 2i and 2i+1 both carry outer bit i.
- R3: The n-th interleaved bit, for n from 0 to 2K-1, is taken from position (step·n + offset) mod 2K.
- R4: After the K systematic bits, exactly V = 2K/J parity bits follow, where J = 2^cfg_jlog. Each parity bit has out_is_parity=1, and out_last=1 only on the final parity bit.
- R5: Parity bit v is p_v = p_{v-1} XOR s_v, with p_{-1} = 0 at the start of every frame. Here s_v is the XOR of interleaved bits vJ through vJ+J-1.
- R6: While a parity bit is offered and out_ready is low, out_valid stays high and out_bit holds its value.
- R7: A frame start is rejected when any of these holds:
  - cfg_jlog is 0 or greater than MAX_JLOG;
  - K is less than 2 or greater than MAX_K;
  - 2K is not a multiple of J;
  - the step is even or not below 2K;
  - the offset is not below 2K.

  A rejected frame gives a one-cycle frame_err pulse in the cycle after its first bit. The block then consumes the frame up to and including in_last and produces no output for it.
- R8: Between frames, input bits without in_first are accepted and discarded, and no output appears.
- R9: During reset and right after it, out_valid=0, frame_err=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_k | input | KW | Frame length K, sampled with the first bit |
| cfg_jlog | input | JLW | log2 of the parity-check group width J |
| cfg_step | input | AW | Interleaver step, odd and coprime with 2K |
| cfg_offset | input | AW | Interleaver start position |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Input bit accepted |
| in_bit | input | 1 | Information bit |
| in_first | input | 1 | Marks the first bit of a frame |
| in_last | input | 1 | Marks the final bit of a frame (used to end a rejected frame) |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream can take a bit |
| out_bit | output | 1 | Codeword bit |
| out_is_parity | output | 1 | High for parity bits |
| out_last | output | 1 | Final bit of the codeword |
| frame_err | output | 1 | One-cycle pulse on a rejected frame |

## Verification
The bench builds the block with MAX_K=64 and MAX_JLOG=4. These values make every group width from 2 to 16 usable, and they let a frame at the largest allowed length and one at the smallest (K=2) run in a few hundred cycles. With this setting, the interleaver covers spans of 4 to 128 positions, both with the identity order and with offsets that wrap. The bench's reference model computes the permuted order with a multiply and a modulo. The block computes it incrementally, so the comparison exercises the wrap-around of the step adder.

// File: rtl/flexenc_pkg.sv
`timescale 1ns/1ps
package flexenc_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_ENC, ST_DROP} enc_state_t;

  // (cur + step) mod span, given cur < span and step < span
  function automatic int unsigned wrap_add(input int unsigned cur,
                                           input int unsigned step,
                                           input int unsigned span);
    int unsigned s;
    s = cur + step;
    return (s >= span) ? s - span : s;
  endfunction

  // index of the last bit in a parity-check group of 2^jlog bits
  function automatic int unsigned group_last(input int unsigned jlog);
    return (32'd1 << jlog) - 32'd1;
  endfunction

  // frame configuration acceptance rule
  function automatic logic cfg_ok(input int unsigned k,
                                  input int unsigned jlog,
                                  input int unsigned step,
                                  input int unsigned offs,
                                  input int unsigned max_k,
                                  input int unsigned max_jlog);
    int unsigned span;
    span = 2 * k;
    return (k >= 2) && (k <= max_k) && (jlog >= 1) && (jlog <= max_jlog) &&
           ((span & group_last(jlog)) == 0) && step[0] &&
           (step < span) && (offs < span);
  endfunction

endpackage

// File: rtl/fe_bit_store.sv
`timescale 1ns/1ps
module fe_bit_store #(
  parameter int MAX_K = 1024,
  parameter int KW    = 11,
  parameter int IW    = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_bit,
  input  logic [KW-1:0] frame_k,
  input  logic [IW-1:0] rd_idx,
  output logic          outer_bit
);
  logic [MAX_K-1:0] mem;
  logic [IW-1:0]    prev_idx;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_bit;
  end

  // tail-biting: the predecessor of bit 0 is bit K-1
  assign prev_idx  = (rd_idx == '0) ? IW'(frame_k - KW'(1)) : rd_idx - IW'(1);
  assign outer_bit = mem[rd_idx] ^ mem[prev_idx];
endmodule

// File: rtl/fe_perm_addr.sv
`timescale 1ns/1ps
module fe_perm_addr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] span,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= offset;
    else if (advance) addr <= AW'(flexenc_pkg::wrap_add(32'(addr), 32'(step), 32'(span)));
  end
endmodule

// File: rtl/fe_spc_acc.sv
`timescale 1ns/1ps
module fe_spc_acc #(
  parameter int JLW = 3,
  parameter int GW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           bit_en,
  input  logic           bit_in,
  input  logic [JLW-1:0] jlog,
  output logic           grp_done,
  output logic           par_next
);
  logic [GW-1:0] gcnt;
  logic [GW-1:0] gmax;
  logic          grp;
  logic          acc;

  assign gmax     = GW'(flexenc_pkg::group_last(32'(jlog)));
  assign grp_done = bit_en && (gcnt == gmax);
  assign par_next = acc ^ grp ^ bit_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt <= '0; grp <= 1'b0; acc <= 1'b0;
    end else if (clear) begin
      gcnt <= '0; grp <= 1'b0; acc <= 1'b0;
    end else if (bit_en) begin
      if (gcnt == gmax) begin
        gcnt <= '0;
        grp  <= 1'b0;
        acc  <= par_next;
      end else begin
        gcnt <= gcnt + GW'(1);
        grp  <= grp ^ bit_in;
      end
    end
  end
endmodule

// File: rtl/flex_sc_ldpc_enc.sv
`timescale 1ns/1ps
module flex_sc_ldpc_enc #(
  parameter int MAX_K    = 1024,
  parameter int MAX_JLOG = 4,
  localparam int KW  = $clog2(MAX_K + 1),
  localparam int AW  = $clog2(2 * MAX_K + 1),
  localparam int JLW = $clog2(MAX_JLOG + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [KW-1:0]  cfg_k,
  input  logic [JLW-1:0] cfg_jlog,
  input  logic [AW-1:0]  cfg_step,
  input  logic [AW-1:0]  cfg_offset,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_bit,
  input  logic           in_first,
  input  logic           in_last,
  output logic           out_valid,
  input  logic           out_ready,
  output logic           out_bit,
  output logic           out_is_parity,
  output logic           out_last,
  output logic           frame_err
);
  import flexenc_pkg::*;

  localparam int IW = $clog2(MAX_K);
  localparam int GW = MAX_JLOG;

  enc_state_t     state;
  logic [KW-1:0]  k_q;
  logic [JLW-1:0] jlog_q;
  logic [AW-1:0]  step_q, offs_q;
  logic [IW-1:0]  widx;
  logic [AW-1:0]  n_cnt;
  logic           gen_done;
  logic           par_valid, par_bit, par_last;

  // named internal events
  logic           cfg_good, in_acc, load_end, enc_start, adv;
  logic           st_load_w, st_drop_w, enc_active_w;
  logic [AW-1:0]  two_k, last_n, cur_addr;
  logic           outer_bit, grp_done, par_next;
  logic           wr_en;
  logic [IW-1:0]  wr_idx;

  assign cfg_good = cfg_ok(32'(cfg_k), 32'(cfg_jlog), 32'(cfg_step), 32'(cfg_offset),
                           32'(MAX_K), 32'(MAX_JLOG));
  assign two_k        = AW'({k_q, 1'b0});
  assign last_n       = two_k - AW'(1);
  assign in_acc       = in_valid && in_ready;
  assign load_end     = (widx == IW'(k_q - KW'(1)));
  assign st_load_w    = (state == ST_LOAD);
  assign st_drop_w    = (state == ST_DROP);
  assign enc_active_w = (state == ST_ENC) && !gen_done;
  assign enc_start    = st_load_w && in_acc && load_end;
  assign adv          = enc_active_w && (!par_valid || out_ready);
  assign wr_en        = in_acc && (st_load_w || ((state == ST_IDLE) && in_first && cfg_good));
  assign wr_idx       = st_load_w ? widx : '0;

  fe_bit_store #(.MAX_K(MAX_K), .KW(KW), .IW(IW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(in_bit),
    .frame_k(k_q), .rd_idx(IW'(cur_addr >> 1)), .outer_bit(outer_bit)
  );

  fe_perm_addr #(.AW(AW)) u_perm (
    .clk(clk), .rst_n(rst_n), .load(enc_start), .advance(adv),
    .step(step_q), .offset(offs_q), .span(two_k), .addr(cur_addr)
  );

  fe_spc_acc #(.JLW(JLW), .GW(GW)) u_spc (
    .clk(clk), .rst_n(rst_n), .clear(enc_start), .bit_en(adv),
    .bit_in(outer_bit), .jlog(jlog_q), .grp_done(grp_done), .par_next(par_next)
  );

  always_comb begin
    in_ready      = 1'b1;
    out_valid     = 1'b0;
    out_bit       = in_bit;
    out_is_parity = 1'b0;
    out_last      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        in_ready  = (in_first && cfg_good) ? out_ready : 1'b1;
        out_valid = in_valid && in_first && cfg_good;
      end
      ST_LOAD: begin
        in_ready  = out_ready;
        out_valid = in_valid;
      end
      ST_ENC: begin
        in_ready      = 1'b0;
        out_valid     = par_valid;
        out_bit       = par_bit;
        out_is_parity = 1'b1;
        out_last      = par_last;
      end
      default: begin
        in_ready = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      k_q       <= '0;
      jlog_q    <= '0;
      step_q    <= '0;
      offs_q    <= '0;
      widx      <= '0;
      n_cnt     <= '0;
      gen_done  <= 1'b0;
      par_valid <= 1'b0;
      par_bit   <= 1'b0;
      par_last  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_acc && in_first) begin
            if (cfg_good) begin
              k_q    <= cfg_k;
              jlog_q <= cfg_jlog;
              step_q <= cfg_step;
              offs_q <= cfg_offset;
              widx   <= IW'(1);
              state  <= ST_LOAD;
            end else begin
              frame_err <= 1'b1;
              if (!in_last) state <= ST_DROP;
            end
          end
        end
        ST_LOAD: begin
          if (in_acc) begin
            if (load_end) begin
              state    <= ST_ENC;
              n_cnt    <= '0;
              gen_done <= 1'b0;
            end else begin
              widx <= widx + IW'(1);
            end
          end
        end
        ST_ENC: begin
          if (adv) begin
            n_cnt <= n_cnt + AW'(1);
            if (n_cnt == last_n) gen_done <= 1'b1;
          end
          if (grp_done) begin
            par_valid <= 1'b1;
            par_bit   <= par_next;
            par_last  <= (n_cnt == last_n);
          end else if (par_valid && out_ready) begin
            par_valid <= 1'b0;
            if (gen_done) state <= ST_IDLE;
          end
        end
        ST_DROP: begin
          if (in_acc && in_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fe_checker.sv
`timescale 1ns/1ps
module fe_checker #(
  parameter int AW  = 12,
  parameter int JLW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           in_bit,
  input logic           out_valid,
  input logic           out_ready,
  input logic           out_bit,
  input logic           out_is_parity,
  input logic           out_last,
  input logic           frame_err,
  input logic           st_load,
  input logic           st_drop,
  input logic           enc_active,
  input logic [AW-1:0]  cur_addr,
  input logic [AW-1:0]  two_k,
  input logic [JLW-1:0] jlog_q
);
  logic [AW-1:0] par_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_cnt <= '0;
    else if (out_valid && out_ready && out_is_parity)
      par_cnt <= out_last ? '0 : par_cnt + AW'(1);
  end

  // R1
  sys_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_load && in_valid && in_ready) |-> (out_valid && !out_is_parity && !out_last && out_bit == in_bit));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_active |-> (cur_addr < two_k));

  // R4
  parity_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_is_parity && out_last) |->
      (({1'b0, par_cnt} + (AW+1)'(1)) == (AW+1)'(two_k >> jlog_q)));

  // R6
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_parity && !out_ready) |=> (out_valid && out_is_parity && $stable(out_bit)));

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R7
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_drop |-> !out_valid);
endmodule

bind flex_sc_ldpc_enc fe_checker #(.AW(AW), .JLW(JLW)) u_fe_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
  .out_is_parity(out_is_parity), .out_last(out_last), .frame_err(frame_err),
  .st_load(st_load_w), .st_drop(st_drop_w), .enc_active(enc_active_w),
  .cur_addr(cur_addr), .two_k(two_k), .jlog_q(jlog_q)
);

// File: tb/tb_flex_sc_ldpc_enc.sv
`timescale 1ns/1ps
module tb_flex_sc_ldpc_enc;
  localparam int MAXK = 64;
  localparam int MAXJ = 4;
  localparam int KW   = $clog2(MAXK + 1);
  localparam int AW   = $clog2(2 * MAXK + 1);
  localparam int JLW  = $clog2(MAXJ + 1);
  localparam int NV   = 8;
  // columns: K, jlog, step, offset, seed
  localparam int VEC [0:NV-1][0:4] = '{
    '{8,  1, 3,  0,   11},
    '{16, 2, 5,  7,   22},
    '{32, 3, 13, 1,   33},
    '{64, 4, 37, 100, 44},
    '{64, 1, 1,  0,   55},
    '{2,  2, 3,  1,   66},
    '{24, 3, 7,  5,   77},
    '{12, 2, 11, 23,  88}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [KW-1:0] cfg_k = '0;
  logic [JLW-1:0] cfg_jlog = '0;
  logic [AW-1:0] cfg_step = '0, cfg_offset = '0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_first = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, out_is_parity, out_last, frame_err;
  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  flex_sc_ldpc_enc #(.MAX_K(MAXK), .MAX_JLOG(MAXJ)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_k(cfg_k), .cfg_jlog(cfg_jlog), .cfg_step(cfg_step),
    .cfg_offset(cfg_offset), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .in_first(in_first), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_is_parity(out_is_parity), .out_last(out_last), .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int k, input int jl, input int st, input int of,
                           input int seed, input bit always_rdy, input bit expect_err);
    bit b [MAXK];
    bit c [MAXK];
    bit ep [MAXK];
    bit got [2*MAXK+8];
    bit gpar [2*MAXK+8];
    bit glast [2*MAXK+8];
    int unsigned x;
    int span, jw, v, total, idx, nout, errs, vis, stall_bad, tail, bad, nlast;
    bit p, s, prev_stall, prev_bit;
    x = seed;
    for (int i = 0; i < k; i++) begin
      x = x * 1103515245 + 12345;
      b[i] = x[16];
    end
    for (int i = 0; i < k; i++) c[i] = b[i] ^ b[(i + k - 1) % k];
    span = 2 * k; jw = 1 << jl; v = span / jw;
    p = 0; s = 0;
    for (int n = 0; n < span; n++) begin
      s = s ^ c[((st * n + of) % span) / 2];
      if ((n + 1) % jw == 0) begin
        p = p ^ s; ep[n / jw] = p; s = 0;
      end
    end
    total = expect_err ? 0 : k + v;
    idx = 0; nout = 0; errs = 0; vis = 0; stall_bad = 0; tail = 0;
    prev_stall = 0; prev_bit = 0;
    @(negedge clk);
    cfg_k = KW'(k); cfg_jlog = JLW'(jl); cfg_step = AW'(st); cfg_offset = AW'(of);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      in_valid = (idx < k);
      in_bit   = (idx < k) ? b[idx] : 1'b0;
      in_first = (idx == 0);
      in_last  = (idx == k - 1);
      out_ready = always_rdy || (((cyc + seed) % 4) != 3);
      #1;
      if (prev_stall && !(out_valid && out_is_parity && out_bit == prev_bit)) stall_bad++;
      prev_stall = out_valid && !out_ready && out_is_parity;
      prev_bit = out_bit;
      if (frame_err) errs++;
      if (out_valid) vis++;
      if (out_valid && out_ready && nout < 2*MAXK+8) begin
        got[nout] = out_bit; gpar[nout] = out_is_parity; glast[nout] = out_last; nout++;
      end
      if (in_valid && in_ready) idx++;
      if (idx >= k && nout >= total) begin
        tail++;
        if (tail > 4) break;
      end
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    if (expect_err) begin
      check(errs == 1, "R7 frame_err pulse count", errs, 1);
      check(vis == 0, "R7 no output for rejected frame", vis, 0);
      check(idx == k, "R7 rejected frame consumed", idx, k);
    end else begin
      bad = 0;
      for (int i = 0; i < k; i++) if (got[i] != b[i] || gpar[i] || glast[i]) bad++;
      check(bad == 0, "R1 systematic bits", bad, 0);
      bad = 0;
      for (int j = 0; j < v; j++) if (got[k + j] != ep[j] || !gpar[k + j]) bad++;
      check(bad == 0, "R2 R3 R5 parity bits", bad, 0);
      nlast = 0;
      for (int i = 0; i < nout; i++) if (glast[i]) nlast++;
      check(nout == k + v && nlast == 1 && glast[k + v - 1], "R4 parity count and last", nout, k + v);
      check(stall_bad == 0, "R6 parity held under backpressure", stall_bad, 0);
      check(errs == 0, "R7 no error on valid frame", errs, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R9 during reset
    check(!out_valid && !frame_err && in_ready, "R9 state during reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid && !frame_err && in_ready, "R9 state after reset", out_valid, 0);
    // R8: stray bits outside a frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1; in_bit = 1'b1; in_first = 0; in_last = (i == 2); out_ready = 1;
      #1;
      check(!out_valid && in_ready, "R8 stray bit discarded", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    for (int r = 0; r < NV; r++)
      run_frame(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], VEC[r][4], r == 4, 1'b0);
    // R7 rejected configurations
    run_frame(6, 3, 5, 0, 5, 1'b1, 1'b1);
    run_frame(8, 1, 4, 0, 6, 1'b1, 1'b1);
    run_frame(8, 1, 3, 16, 7, 1'b1, 1'b1);
    run_frame(1, 1, 1, 0, 8, 1'b1, 1'b1);
    // recovery after rejections
    run_frame(20, 2, 9, 39, 99, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule